// File: doc/BRIEF.md
# Upper Memory Bank Mapper

This block decodes the 16-bit address bus of an 8-bit CPU and steers each access to 64 KiB of external RAM, a 12 KiB upper ROM, a pair of 4 KiB peripheral ROM images, or the I/O page. The region from $D000 to $FFFF is switchable. Reads there come either from the upper ROM or from RAM. RAM there may be write-protected. The 4 KiB window at $D000-$DFFF can show either of two RAM banks.

Software changes the switchable state by touching any address from $C080 to $C08F. Either a read or a write does this. The low four address bits form the command. Bank 1 of the $D000 window lives in the physical RAM that the I/O and peripheral ROM space hides at $C000-$CFFF. Bank 2 lives at its own address.

Every access is taken in one cycle, and the block presents registered chip selects, write enable and physical addresses in the following cycle. A separate flag picks which peripheral ROM image answers reads at $C100-$CFFF.

Top module: `upper_bank_mapper`

## Requirements
- R1: A read or write in $C080-$C08F sets all three switch bits in one step from the address bits [3:0]. The new setting applies from the next access onward.
- R2: Command bit 0 equal to 0 write-protects $D000-$FFFF RAM; equal to 1 makes it writable.
- R3: Upper reads go to RAM when command bit 1 XOR bit 0 is 0, and to the upper ROM when it is 1.
- R4: Command bit 3 equal to 1 selects bank 1 for $D000-$DFFF; equal to 0 selects bank 2.
- R5: With bank 1, addresses $Dxxx use physical RAM $Cxxx. With bank 2 they use $Dxxx. $E000-$FFFF always uses the identical physical RAM address.
- R6: An upper write while protected asserts no strobe. An upper write while not protected goes to RAM even when upper reads come from ROM. At most one of ram_cs, urom_cs, prom_cs and io_sel is high.
- R7: Accesses below $C000 reach RAM at the identical address, and writes assert ram_we.
- R8: Accesses to $C000-$C0FF raise only io_sel. Reads of $C100-$CFFF raise prom_cs, with prom_addr[12] equal to prom_bank and prom_addr[11:0] equal to the address bits [11:0]. Writes there assert nothing.
- R9: After reset, upper reads come from ROM, upper RAM is writable, and bank 2 is selected.
- R10: An upper ROM read drives urom_addr equal to the address minus $D000.
- R11: Outputs follow the access by one clock. With no access, all selects and the write enable are 0. Any address output whose select is low is 0. ram_wdata is the data input of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Bus address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| prom_bank | input | 1 | Peripheral ROM image select |
| ram_cs | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | Physical RAM address |
| ram_wdata | output | 8 | RAM write data |
| urom_cs | output | 1 | Upper ROM select |
| urom_addr | output | 14 | Upper ROM offset |
| prom_cs | output | 1 | Peripheral ROM select |
| prom_addr | output | 13 | Peripheral ROM address, image in bit 12 |
| io_sel | output | 1 | I/O page access |

## Verification
Several properties hold on every cycle: the selects are mutually exclusive, an idle cycle drives no strobe, low RAM passes its address through unchanged, and peripheral-space writes never strobe anything. One property follows a specific command: after $C08B, a write to $D000 lands at physical $C000. The remaining mapping properties depend on the switch history, and only the bench shows them. It walks all sixteen commands, issued both as reads and as writes. After each command it probes the bank window, the fixed upper area and the protected writes against a model built from the requirements.

// File: rtl/upper_bank_mapper.sv
module upper_bank_mapper #(
  parameter int UROM_BYTES = 12288,
  parameter int PROM_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [7:0]  cpu_wdata,
  input  logic        prom_bank,
  output logic        ram_cs,
  output logic        ram_we,
  output logic [15:0] ram_addr,
  output logic [7:0]  ram_wdata,
  output logic        urom_cs,
  output logic [13:0] urom_addr,
  output logic        prom_cs,
  output logic [12:0] prom_addr,
  output logic        io_sel
);
  localparam int UROM_AW = $clog2(UROM_BYTES);
  localparam int PROM_OW = $clog2(PROM_BYTES);

  logic wprot, rd_rom, bank_one;

  logic acc, in_low, in_io, in_per, in_up, is_cmd;
  logic [15:0] phys, up_off;

  assign acc    = cpu_rd | cpu_wr;
  assign in_low = cpu_addr < 16'hC000;
  assign in_io  = cpu_addr[15:8] == 8'hC0;
  assign in_per = cpu_addr[15:12] == 4'hC && !in_io;
  assign in_up  = cpu_addr[15:12] >= 4'hD;
  assign is_cmd = cpu_addr[15:4] == 12'hC08;
  assign phys   = (cpu_addr[15:12] == 4'hD && bank_one) ? {4'hC, cpu_addr[11:0]} : cpu_addr;
  assign up_off = cpu_addr - 16'hD000;

  logic n_ram_cs, n_ram_we, n_urom_cs, n_prom_cs, n_io;
  logic [15:0] n_ram_addr;
  logic [13:0] n_urom_addr;
  logic [12:0] n_prom_addr;

  always_comb begin
    n_ram_cs = 1'b0; n_ram_we = 1'b0; n_ram_addr = '0;
    n_urom_cs = 1'b0; n_urom_addr = '0;
    n_prom_cs = 1'b0; n_prom_addr = '0;
    n_io = 1'b0;
    if (acc) begin
      if (in_low) begin
        n_ram_cs = 1'b1; n_ram_we = cpu_wr; n_ram_addr = cpu_addr;
      end else if (in_io) begin
        n_io = 1'b1;
      end else if (in_per) begin
        if (!cpu_wr) begin
          n_prom_cs = 1'b1;
          n_prom_addr = {prom_bank, cpu_addr[PROM_OW-1:0]};
        end
      end else if (in_up) begin
        if (cpu_wr) begin
          if (!wprot) begin
            n_ram_cs = 1'b1; n_ram_we = 1'b1; n_ram_addr = phys;
          end
        end else if (rd_rom) begin
          n_urom_cs = 1'b1; n_urom_addr = up_off[UROM_AW-1:0];
        end else begin
          n_ram_cs = 1'b1; n_ram_addr = phys;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wprot <= 1'b0; rd_rom <= 1'b1; bank_one <= 1'b0;
      ram_cs <= 1'b0; ram_we <= 1'b0; ram_addr <= '0; ram_wdata <= '0;
      urom_cs <= 1'b0; urom_addr <= '0;
      prom_cs <= 1'b0; prom_addr <= '0; io_sel <= 1'b0;
    end else begin
      if (acc && is_cmd) begin
        wprot    <= ~cpu_addr[0];
        rd_rom   <= cpu_addr[1] ^ cpu_addr[0];
        bank_one <= cpu_addr[3];
      end
      ram_cs <= n_ram_cs; ram_we <= n_ram_we; ram_addr <= n_ram_addr;
      ram_wdata <= cpu_wdata;
      urom_cs <= n_urom_cs; urom_addr <= n_urom_addr;
      prom_cs <= n_prom_cs; prom_addr <= n_prom_addr;
      io_sel <= n_io;
    end
  end
endmodule

module upper_bank_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic        ram_cs,
  input logic        ram_we,
  input logic [15:0] ram_addr,
  input logic        urom_cs,
  input logic [13:0] urom_addr,
  input logic        prom_cs,
  input logic        io_sel
);
  // R6
  sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_cs, urom_cs, prom_cs, io_sel}));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rd && !cpu_wr) |=> !(ram_cs || ram_we || urom_cs || prom_cs || io_sel));
  // R7
  low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_rd || cpu_wr) && cpu_addr < 16'hC000) |=> (ram_cs && ram_addr == $past(cpu_addr)));
  // R8
  per_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:12] == 4'hC && cpu_addr[15:8] != 8'hC0) |=> !(ram_we || prom_cs || ram_cs));
  // R10
  urom_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    urom_cs |-> urom_addr < 14'd12288);
  // R5
  bank_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_rd || cpu_wr) && cpu_addr == 16'hC08B) ##1 (cpu_wr && !cpu_rd && cpu_addr == 16'hD000)
      |=> (ram_we && ram_addr == 16'hC000));
endmodule

bind upper_bank_mapper upper_bank_mapper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr), .urom_cs(urom_cs),
  .urom_addr(urom_addr), .prom_cs(prom_cs), .io_sel(io_sel)
);

// File: tb/upper_bank_mapper_bench.sv
module upper_bank_mapper_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0, prom_bank = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic ram_cs, ram_we, urom_cs, prom_cs, io_sel;
  logic [15:0] ram_addr;
  logic [7:0] ram_wdata;
  logic [13:0] urom_addr;
  logic [12:0] prom_addr;

  always #2 clk = ~clk;

  upper_bank_mapper u_upper_bank_mapper (.*);

  int checks = 0, fails = 0;
  bit m_wp = 0, m_rom = 1, m_b1 = 0;

  function automatic logic [55:0] model(input logic [15:0] a, input bit rd, input bit wr,
                                        input logic [7:0] d, input bit sel);
    logic rc = 0, we = 0, uc = 0, pc = 0, io = 0;
    logic [15:0] ra = 0; logic [13:0] ua = 0; logic [12:0] pa = 0;
    int ai = int'(a);
    if (rd || wr) begin
      if (ai < 'hC000) begin rc = 1; we = wr; ra = a; end
      else if (ai < 'hC100) io = 1;
      else if (ai < 'hD000) begin if (!wr) begin pc = 1; pa = 13'(ai - 'hC000 + (sel ? 4096 : 0)); end end
      else begin
        int pai = (ai < 'hE000 && m_b1) ? ai - 'h1000 : ai;
        if (wr) begin if (!m_wp) begin rc = 1; we = 1; ra = 16'(pai); end end
        else if (m_rom) begin uc = 1; ua = 14'(ai - 'hD000); end
        else begin rc = 1; ra = 16'(pai); end
      end
    end
    return {io, rc, we, ra, d, uc, ua, pc, pa};
  endfunction

  task automatic access(input logic [15:0] a, input bit rd, input bit wr,
                        input logic [7:0] d, input string req);
    logic [55:0] exp, got;
    exp = model(a, rd, wr, d, prom_bank);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = d;
    @(negedge clk);
    cpu_rd = 0; cpu_wr = 0;
    got = {io_sel, ram_cs, ram_we, ram_addr, ram_wdata, urom_cs, urom_addr, prom_cs, prom_addr};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s addr=%h rd=%0b wr=%0b actual=%h expected=%h", req, a, rd, wr, got, exp);
    end
    if ((rd || wr) && a[15:4] == 12'hC08) begin
      m_wp = ~a[0]; m_rom = a[1] ^ a[0]; m_b1 = a[3];
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({ram_cs, ram_we, urom_cs, prom_cs, io_sel} !== 5'b0) begin
      fails++; $display("FAIL R11 reset outputs actual=%b expected=00000",
                        {ram_cs, ram_we, urom_cs, prom_cs, io_sel});
    end
    rst_n = 1;
    access(16'hD000, 1, 0, 8'h00, "R9 reset reads ROM");
    access(16'hD123, 0, 1, 8'h5A, "R9 reset writable bank2");
    access(16'hFFFF, 1, 0, 8'h00, "R10 ROM top offset");
    access(16'h0000, 0, 0, 8'h11, "R11 idle");
    for (int a = 0; a < 'hC000; a += 'h0BF7) begin
      access(16'(a), 1, 0, 8'h00, "R7 low read");
      access(16'(a), 0, 1, 8'(a), "R7 low write");
    end
    access(16'hC000, 1, 0, 8'h00, "R8 io read");
    access(16'hC0FF, 0, 1, 8'h33, "R8 io write");
    for (int s = 0; s < 2; s++) begin
      prom_bank = s[0];
      access(16'hC100, 1, 0, 8'h00, "R8 periph read low");
      access(16'hCFFF, 1, 0, 8'h00, "R8 periph read high");
      access(16'hC600, 0, 1, 8'h77, "R8 periph write ignored");
    end
    for (int pass = 0; pass < 2; pass++) begin
      for (int m = 0; m < 16; m++) begin
        access(16'hC080 + 16'(m), pass == 0, pass == 1, 8'h00, "R1 command");
        access(16'hD000, 1, 0, 8'h00, "R3 R4 R5 bank window read");
        access(16'hDABC, 0, 1, 8'hA5, "R2 R5 R6 bank window write");
        access(16'hE123, 1, 0, 8'h00, "R3 R5 R10 fixed upper read");
        access(16'hFFFF, 0, 1, 8'h3C, "R2 R6 fixed upper write");
        access(16'h1234, 1, 0, 8'h00, "R7 low unaffected");
      end
    end
    access(16'hC08B, 1, 0, 8'h00, "R1 command bank1 RAM");
    access(16'hC081, 0, 1, 8'h00, "R1 back-to-back command");
    access(16'hD001, 0, 1, 8'h44, "R6 write under ROM read");
    access(16'hD001, 1, 0, 8'h00, "R3 ROM read after 81");
    finish_run();
  end
endmodule